// File: doc/BRIEF.md
# Tearing-Effect Sync Gate

This block decides when a panel frame transfer may begin. A display module reports its refresh position on a single tearing-effect pin. Both its line pulses (horizontal sync) and its frame pulses (vertical sync) appear on that one pin, and the only difference between them is how long they last. The gate passes the pin through a synchronizer and measures each run of the pin at its active level in clock cycles (ticks). It then sorts each pulse by comparing its length with two programmed widths. When the programmed condition is met, it sends a single-cycle `go` pulse to the frame packer.

Software arms the gate with a one-cycle `start_req`. Mode 1 releases the transfer at the first vertical sync. Mode 2 waits for a vertical sync and then counts line pulses until the count reaches a programmed line number. When tearing sync is off, or when `start_now` accompanies the request, the transfer is released at once. The programmed values must follow three rules: the horizontal width is at least 2, the vertical width is at least 2 in mode 2 and at least 4 in mode 1, and the two widths differ.

Top module: `te_sync_gate`

## Requirements
- R1: While reset is asserted and after it is released, `go` is 0 and the gate is not armed.
- R2: Mode codes 0 and 3 disable tearing sync. In these modes, `start_req` makes `go` high in the clock cycle right after the request cycle.
- R3: `start_req` together with `start_now` makes `go` high in the next cycle in every mode, and no sync pulse is needed.
- R4: A completed run of the synchronized pin at the vertical active level is a vertical sync when it lasts at least `vs_width` ticks. A run at the horizontal active level that is not a vertical sync is a horizontal sync when it lasts at least `hs_width` ticks. All other runs are ignored. A run of exactly `vs_width` ticks is a vertical sync, and a run of `vs_width-1` ticks is a horizontal sync when the two active levels are the same.
- R5: Each polarity input set to 1 makes that sync active high, and set to 0 makes it active low. A run at the level opposite to a sync kind's active level never counts as that kind.
- R6: In mode 1, an armed gate raises `go` at the first vertical sync. `go` is seen `SYNC_STAGES`+1 clock cycles after the pulse's trailing edge at the pin.
- R7: In mode 2, an armed gate ignores horizontal syncs until a vertical sync arrives. It then counts horizontal syncs and raises `go` when the count equals `target_line`. A `target_line` of 0 releases at the vertical sync itself. A further vertical sync before the target line is reached restarts the count from 0.
- R8: Each accepted start request produces exactly one `go`. Syncs that arrive while the gate is not armed have no effect. A `start_req` made while the gate is armed, including one with `start_now`, is ignored.
- R9: `go` is high for one clock cycle per release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one tick |
| rst_n | input | 1 | Active-low synchronous reset |
| te_pin | input | 1 | Asynchronous tearing-effect pin from the panel |
| te_mode | input | 2 | 0/3 off, 1 vertical sync only, 2 vertical sync plus line count |
| hs_active_high | input | 1 | 1 = horizontal sync pulses are high |
| vs_active_high | input | 1 | 1 = vertical sync pulses are high |
| hs_width | input | WIDTH_W | Minimum horizontal sync length in ticks |
| vs_width | input | WIDTH_W | Minimum vertical sync length in ticks |
| target_line | input | LINE_W | Line pulses to count after vertical sync in mode 2 |
| start_req | input | 1 | One-cycle request to arm or start a transfer |
| start_now | input | 1 | Qualifies `start_req` to bypass tearing sync |
| go | output | 1 | One-cycle permit to begin the frame transfer |

## Verification
The bench probes the width boundaries directly. A pulse of exactly `vs_width` or `hs_width` ticks must be accepted, and a pulse one tick shorter must be demoted or ignored, so a design that uses a strict comparison releases too late or never releases. Mode 2 is run with a line count of 0, with a count that is never reached, with surplus line pulses, and with a second vertical sync partway through the count. These cases catch a counter that is off by one, that fires more than once, or that does not restart. Mixed polarities are used to show that a line pulse at the frame-pulse level is not counted. Repeated start requests while the gate is armed must not produce an extra `go`.

// File: rtl/te_sync_gate.sv
module te_sync_gate #(
  parameter int SYNC_STAGES = 2,
  parameter int WIDTH_W     = 8,
  parameter int LINE_W      = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               te_pin,
  input  logic [1:0]         te_mode,
  input  logic               hs_active_high,
  input  logic               vs_active_high,
  input  logic [WIDTH_W-1:0] hs_width,
  input  logic [WIDTH_W-1:0] vs_width,
  input  logic [LINE_W-1:0]  target_line,
  input  logic               start_req,
  input  logic               start_now,
  output logic               go
);

  localparam logic [WIDTH_W-1:0] RUN_MAX = '1;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT_VS, ST_COUNT} state_t;

  state_t              state;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                te_d;
  logic [WIDTH_W-1:0]  run_len;
  logic [LINE_W-1:0]   line_cnt;

  wire te_s      = sync_q[SYNC_STAGES-1];
  wire run_end   = te_s != te_d;
  wire vs_evt    = run_end && (te_d == vs_active_high) && (run_len >= vs_width);
  wire hs_evt    = run_end && (te_d == hs_active_high) && (run_len >= hs_width) && !vs_evt;
  wire sync_off  = (te_mode == 2'd0) || (te_mode == 2'd3);
  wire [LINE_W-1:0] line_next = line_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= '0;
      te_d    <= 1'b0;
      run_len <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], te_pin};
      te_d   <= te_s;
      if (run_end)
        run_len <= {{(WIDTH_W-1){1'b0}}, 1'b1};
      else if (run_len != RUN_MAX)
        run_len <= run_len + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      line_cnt <= '0;
      go       <= 1'b0;
    end else begin
      go <= 1'b0;
      case (state)
        ST_IDLE:
          if (start_req) begin
            if (start_now || sync_off) go <= 1'b1;
            else                       state <= ST_WAIT_VS;
          end
        ST_WAIT_VS:
          if (vs_evt) begin
            if (te_mode == 2'd1 || target_line == '0) begin
              go    <= 1'b1;
              state <= ST_IDLE;
            end else begin
              line_cnt <= '0;
              state    <= ST_COUNT;
            end
          end
        ST_COUNT:
          if (vs_evt) begin
            line_cnt <= '0;
            if (target_line == '0) begin
              go    <= 1'b1;
              state <= ST_IDLE;
            end
          end else if (hs_evt) begin
            if (line_next == target_line) begin
              go    <= 1'b1;
              state <= ST_IDLE;
            end else begin
              line_cnt <= line_next;
            end
          end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_disabled_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start_req && sync_off) |=> go);

  assert_force_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start_req && start_now) |=> go);

  assert_mode1_vsync_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_VS && vs_evt && te_mode == 2'd1) |=> (go && state == ST_IDLE));

  assert_wait_hs_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_VS && !vs_evt) |=> !go);

  assert_line_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COUNT && hs_evt && !vs_evt && line_next == target_line) |=> (go && state == ST_IDLE));

  assert_no_go_unarmed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !start_req) |=> !go);

endmodule

// File: tb/test_te_sync_gate.sv
`timescale 1ns/1ps
module test_te_sync_gate;
  localparam int WIDTH_W = 8;
  localparam int LINE_W  = 11;
  localparam int LAT     = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic te_pin = 1'b0;
  logic [1:0] te_mode = 2'd0;
  logic hs_active_high = 1'b1;
  logic vs_active_high = 1'b1;
  logic [WIDTH_W-1:0] hs_width = 8'd3;
  logic [WIDTH_W-1:0] vs_width = 8'd6;
  logic [LINE_W-1:0] target_line = '0;
  logic start_req = 1'b0;
  logic start_now = 1'b0;
  logic go;

  te_sync_gate #(.SYNC_STAGES(2), .WIDTH_W(WIDTH_W), .LINE_W(LINE_W)) i_te_sync_gate (
    .clk(clk), .rst_n(rst_n), .te_pin(te_pin), .te_mode(te_mode),
    .hs_active_high(hs_active_high), .vs_active_high(vs_active_high),
    .hs_width(hs_width), .vs_width(vs_width), .target_line(target_line),
    .start_req(start_req), .start_now(start_now), .go(go));

  always #2.5 clk = ~clk;

  int cyc = 0;
  int go_cnt = 0;
  int last_go_cyc = -1;
  int end_cyc = 0;
  int start_cyc = 0;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (go) begin go_cnt++; last_go_cyc = cyc; end

  // {do_start, mode, line, n_hs, expected go count}
  localparam int NV = 8;
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 2'd1, 11'd5, 8'd0, 2'd1},
    {1'b1, 2'd2, 11'd0, 8'd0, 2'd1},
    {1'b1, 2'd2, 11'd3, 8'd2, 2'd0},
    {1'b1, 2'd2, 11'd3, 8'd3, 2'd1},
    {1'b1, 2'd2, 11'd3, 8'd6, 2'd1},
    {1'b1, 2'd1, 11'd0, 8'd4, 2'd1},
    {1'b1, 2'd2, 11'd1, 8'd1, 2'd1},
    {1'b0, 2'd1, 11'd0, 8'd2, 2'd0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_start(input bit now);
    @(negedge clk);
    start_req = 1'b1;
    start_now = now;
    start_cyc = cyc;
    @(negedge clk);
    start_req = 1'b0;
    start_now = 1'b0;
  endtask

  task automatic pulse(input logic lvl, input int n, input int gap);
    @(negedge clk);
    te_pin = lvl;
    repeat (n) @(negedge clk);
    te_pin = ~lvl;
    end_cyc = cyc;
    repeat (gap) @(negedge clk);
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int base;
    logic v_start;
    logic [1:0] v_mode;
    logic [LINE_W-1:0] v_line;
    logic [7:0] v_nhs;
    logic [1:0] v_exp;

    repeat (2) @(negedge clk);
    #1;
    check(go == 1'b0, "R1 go in reset", go, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    #1;
    check(go_cnt == 0, "R1 go after reset", go_cnt, 0);

    for (int i = 0; i < NV; i++) begin
      {v_start, v_mode, v_line, v_nhs, v_exp} = VEC[i];
      apply_reset();
      te_mode = v_mode;
      target_line = v_line;
      base = go_cnt;
      if (v_start) do_start(1'b0);
      pulse(1'b1, 8, 4);
      for (int k = 0; k < int'(v_nhs); k++) pulse(1'b1, 4, 4);
      settle();
      if (!v_start)
        check(go_cnt - base == int'(v_exp), "R8 unarmed", go_cnt - base, int'(v_exp));
      else if (v_mode == 2'd1)
        check(go_cnt - base == int'(v_exp), "R6 table", go_cnt - base, int'(v_exp));
      else
        check(go_cnt - base == int'(v_exp), "R7 table", go_cnt - base, int'(v_exp));
    end

    // R2 disabled modes release in the next cycle, one cycle wide (R9)
    apply_reset();
    te_mode = 2'd0;
    base = go_cnt;
    do_start(1'b0);
    #1;
    check(last_go_cyc == start_cyc + 1, "R2 mode0 latency", last_go_cyc - start_cyc, 1);
    settle();
    check(go_cnt - base == 1, "R9 single go", go_cnt - base, 1);
    te_mode = 2'd3;
    base = go_cnt;
    do_start(1'b0);
    settle();
    check(go_cnt - base == 1 && last_go_cyc == start_cyc + 1, "R2 mode3", go_cnt - base, 1);

    // R3 forced start in mode 2
    apply_reset();
    te_mode = 2'd2;
    target_line = 11'd4;
    base = go_cnt;
    do_start(1'b1);
    settle();
    check(go_cnt - base == 1 && last_go_cyc == start_cyc + 1, "R3 forced", last_go_cyc - start_cyc, 1);

    // R6 latency from trailing edge of vertical sync
    apply_reset();
    te_mode = 2'd1;
    do_start(1'b0);
    pulse(1'b1, 8, 0);
    settle();
    check(last_go_cyc - end_cyc == LAT, "R6 latency", last_go_cyc - end_cyc, LAT);

    // R4 width boundaries in mode 1
    apply_reset();
    te_mode = 2'd1;
    base = go_cnt;
    do_start(1'b0);
    pulse(1'b1, 2, 4);
    pulse(1'b1, 3, 4);
    pulse(1'b1, 5, 4);
    settle();
    check(go_cnt - base == 0, "R4 below vs_width", go_cnt - base, 0);
    pulse(1'b1, 6, 4);
    settle();
    check(go_cnt - base == 1, "R4 exact vs_width", go_cnt - base, 1);

    // R4 horizontal boundary in mode 2
    apply_reset();
    te_mode = 2'd2;
    target_line = 11'd1;
    base = go_cnt;
    do_start(1'b0);
    pulse(1'b1, 8, 4);
    pulse(1'b1, 2, 4);
    settle();
    check(go_cnt - base == 0, "R4 below hs_width", go_cnt - base, 0);
    pulse(1'b1, 3, 4);
    settle();
    check(go_cnt - base == 1, "R4 exact hs_width", go_cnt - base, 1);
    apply_reset();
    base = go_cnt;
    do_start(1'b0);
    pulse(1'b1, 8, 4);
    pulse(1'b1, 5, 4);
    settle();
    check(go_cnt - base == 1, "R4 vs_width-1 is hsync", go_cnt - base, 1);

    // R5 active-low vertical sync
    te_pin = 1'b1;
    vs_active_high = 1'b0;
    hs_active_high = 1'b0;
    apply_reset();
    te_mode = 2'd1;
    base = go_cnt;
    do_start(1'b0);
    settle();
    check(go_cnt - base == 0, "R5 idle high", go_cnt - base, 0);
    pulse(1'b0, 8, 4);
    settle();
    check(go_cnt - base == 1, "R5 low vsync", go_cnt - base, 1);

    // R5 mixed polarity: vertical high, horizontal low
    te_pin = 1'b0;
    vs_active_high = 1'b1;
    hs_active_high = 1'b0;
    apply_reset();
    te_mode = 2'd2;
    target_line = 11'd2;
    base = go_cnt;
    do_start(1'b0);
    pulse(1'b1, 8, 4);
    @(negedge clk); te_pin = 1'b1;
    repeat (4) @(negedge clk); te_pin = 1'b0;
    settle();
    check(go_cnt - base == 0, "R5 high run not hsync", go_cnt - base, 0);
    @(negedge clk); te_pin = 1'b1;
    settle();
    check(go_cnt - base == 1, "R5 second low hsync", go_cnt - base, 1);
    @(negedge clk); te_pin = 1'b0;
    hs_active_high = 1'b1;
    apply_reset();

    // R8 start while armed ignored, single release
    te_mode = 2'd1;
    base = go_cnt;
    do_start(1'b0);
    do_start(1'b1);
    settle();
    check(go_cnt - base == 0, "R8 restart ignored", go_cnt - base, 0);
    pulse(1'b1, 8, 4);
    pulse(1'b1, 8, 4);
    settle();
    check(go_cnt - base == 1, "R8 one go per start", go_cnt - base, 1);

    // R7 second vertical sync restarts the count
    apply_reset();
    te_mode = 2'd2;
    target_line = 11'd3;
    base = go_cnt;
    do_start(1'b0);
    pulse(1'b1, 4, 4);
    pulse(1'b1, 8, 4);
    pulse(1'b1, 4, 4);
    pulse(1'b1, 4, 4);
    pulse(1'b1, 8, 4);
    pulse(1'b1, 4, 4);
    pulse(1'b1, 4, 4);
    settle();
    check(go_cnt - base == 0, "R7 count restarted", go_cnt - base, 0);
    pulse(1'b1, 4, 0);
    settle();
    check(go_cnt - base == 1 && last_go_cyc - end_cyc == LAT, "R7 release", go_cnt - base, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule